// File: doc/BRIEF.md
# Two-Direction Intersection Lamp Sequencer

This block drives the lamps of a crossing where an east-west road meets a north-south road. Each road has a red, an amber and a green lamp, all active high (a high output lights the lamp). The two roads take turns: the road that has right of way shows a steady green, then a flashing green, then amber. For the whole of that turn the other road shows red. Then the roles swap, and the whole pattern repeats without end.

Every lamp output is the Q pin of its own flip-flop. The value loaded into each lamp flop is decoded from the sequencer's next phase and next count. The lamps therefore change on the same clock edge as the phase they belong to, and no decoding logic sits between a register and a pin. The asynchronous active-low reset is asserted at once and released through a synchronizer. The cycle counts of the three phases are parameters. Their defaults are 7 cycles of steady green, 4 cycles of flash and 3 cycles of amber, which gives a 28-cycle round.

Top module: `tl_crossing_ctrl`

## Requirements
- R1: While rst_n is low, the outputs show the start-up pattern: ew_go=1, ns_red=1, and the other four lamps 0.
- R2: After rst_n rises, the pattern first moves on at the third rising clock edge. Up to that edge the start-up pattern (position 0) is held. Each later rising edge advances the position by one, modulo 28.
- R3: At positions 0 to 6, east-west shows only green (7 cycles of steady green).
- R4: At positions 7 to 10, east-west green is off, on, off, on, in that order, and east-west amber and red stay dark.
- R5: At positions 11 to 13, east-west shows only amber, with green off. At position 14 east-west turns red at once and stays red through position 27 (14 cycles).
- R6: North-south shows the same pattern shifted by 14 positions. While east-west shows green or amber, north-south shows red. After position 27 the sequence returns to position 0.
- R7: The two amber outputs are never high in the same cycle.
- R8: Each road has at most one lamp lit in any cycle. All three are dark in the off cycles of the flash.
- R9: Lowering rst_n at any point forces the start-up pattern at the outputs without waiting for a clock edge. The sequence then restarts as in R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencing clock; one step per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ew_red | output | 1 | East-west red lamp |
| ew_amber | output | 1 | East-west amber lamp |
| ew_go | output | 1 | East-west green lamp |
| ns_red | output | 1 | North-south red lamp |
| ns_amber | output | 1 | North-south amber lamp |
| ns_go | output | 1 | North-south green lamp |

## Verification
The only stimulus the block accepts is time and reset. The bench therefore walks three complete 28-cycle rounds and compares all six lamps every cycle against a position computed from the number of edges counted since reset. This separates errors in phase length, in the flash polarity and in the direction swap. A second reset is applied in the middle of the amber phase. Checking the outputs before the next clock edge shows whether the reset acts asynchronously, and the run after it shows whether the synchronizer delay and the restart position are right.

// File: rtl/tl_pkg.sv
package tl_pkg;

  typedef enum logic [1:0] {
    PH_GO      = 2'd0,
    PH_FLASH   = 2'd1,
    PH_CAUTION = 2'd2
  } phase_e;

  typedef enum logic {
    DIR_EW = 1'b0,
    DIR_NS = 1'b1
  } dir_e;

  typedef struct packed {
    logic red;
    logic amber;
    logic go;
  } lamp_t;

  localparam lamp_t LAMP_DARK  = '{red: 1'b0, amber: 1'b0, go: 1'b0};
  localparam lamp_t LAMP_RED   = '{red: 1'b1, amber: 1'b0, go: 1'b0};
  localparam lamp_t LAMP_AMBER = '{red: 1'b0, amber: 1'b1, go: 1'b0};
  localparam lamp_t LAMP_GO    = '{red: 1'b0, amber: 1'b0, go: 1'b1};

endpackage

// File: rtl/tl_reset_sync.sv
module tl_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/tl_phase_seq.sv
module tl_phase_seq
  import tl_pkg::*;
#(
  parameter int GO_CYC      = 7,
  parameter int FLASH_CYC   = 4,
  parameter int CAUTION_CYC = 3,
  parameter int CNT_W       = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  output phase_e           phase_d,
  output dir_e             dir_d,
  output logic [CNT_W-1:0] cnt_d
);

  localparam logic [CNT_W-1:0] GO_LAST      = CNT_W'(GO_CYC - 1);
  localparam logic [CNT_W-1:0] FLASH_LAST   = CNT_W'(FLASH_CYC - 1);
  localparam logic [CNT_W-1:0] CAUTION_LAST = CNT_W'(CAUTION_CYC - 1);

  phase_e           phase_q;
  dir_e             dir_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_cnt;
  logic             at_last;

  // Length of the current phase.
  always_comb begin
    unique case (phase_q)
      PH_GO:      last_cnt = GO_LAST;
      PH_FLASH:   last_cnt = FLASH_LAST;
      PH_CAUTION: last_cnt = CAUTION_LAST;
      default:    last_cnt = '0;
    endcase
  end

  assign at_last = (cnt_q == last_cnt);

  // Next-state process.
  always_comb begin
    phase_d = phase_q;
    dir_d   = dir_q;
    cnt_d   = cnt_q;
    if (step_en) begin
      if (at_last) begin
        cnt_d = '0;
        unique case (phase_q)
          PH_GO:      phase_d = PH_FLASH;
          PH_FLASH:   phase_d = PH_CAUTION;
          PH_CAUTION: begin
            phase_d = PH_GO;
            dir_d   = (dir_q == DIR_EW) ? DIR_NS : DIR_EW;
          end
          default: begin
            phase_d = PH_GO;
            dir_d   = DIR_EW;
          end
        endcase
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  // Register process.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_GO;
      dir_q   <= DIR_EW;
      cnt_q   <= '0;
    end else if (step_en) begin
      phase_q <= phase_d;
      dir_q   <= dir_d;
      cnt_q   <= cnt_d;
    end
  end

endmodule

// File: rtl/tl_lamp_decode.sv
module tl_lamp_decode
  import tl_pkg::*;
#(
  parameter bit OWN_DIR = 1'b0
) (
  input  phase_e phase,
  input  dir_e   dir,
  input  logic   flash_lit,
  output lamp_t  lamp
);

  always_comb begin
    lamp = LAMP_RED;
    if (dir == dir_e'(OWN_DIR)) begin
      unique case (phase)
        PH_GO:      lamp = LAMP_GO;
        PH_FLASH:   lamp = flash_lit ? LAMP_GO : LAMP_DARK;
        PH_CAUTION: lamp = LAMP_AMBER;
        default:    lamp = LAMP_RED;
      endcase
    end
  end

endmodule

// File: rtl/tl_crossing_ctrl.sv
module tl_crossing_ctrl
  import tl_pkg::*;
#(
  parameter int GO_CYC      = 7,
  parameter int FLASH_CYC   = 4,
  parameter int CAUTION_CYC = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic ew_red,
  output logic ew_amber,
  output logic ew_go,
  output logic ns_red,
  output logic ns_amber,
  output logic ns_go
);

  localparam int MAX_CYC = (GO_CYC > FLASH_CYC)
                         ? ((GO_CYC > CAUTION_CYC) ? GO_CYC : CAUTION_CYC)
                         : ((FLASH_CYC > CAUTION_CYC) ? FLASH_CYC : CAUTION_CYC);
  localparam int CNT_W   = (MAX_CYC > 2) ? $clog2(MAX_CYC) : 1;
  localparam int N_DIR   = 2;

  logic             rst_sync_n;
  logic             step_en;
  phase_e           phase_d;
  dir_e             dir_d;
  logic [CNT_W-1:0] cnt_d;
  lamp_t            lamp_d [N_DIR];
  lamp_t            lamp_q [N_DIR];

  tl_reset_sync #(.STAGES(SYNC_STAGES)) u_rsync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  // The sequencer steps every cycle once reset is released.
  assign step_en = 1'b1;

  tl_phase_seq #(
    .GO_CYC     (GO_CYC),
    .FLASH_CYC  (FLASH_CYC),
    .CAUTION_CYC(CAUTION_CYC),
    .CNT_W      (CNT_W)
  ) u_seq (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .step_en(step_en),
    .phase_d(phase_d),
    .dir_d  (dir_d),
    .cnt_d  (cnt_d)
  );

  // One decoder and one output register per direction. The decoder looks
  // at the next state, so each register holds the lamps of the state the
  // sequencer is now in.
  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    localparam lamp_t START = (d == 0) ? LAMP_GO : LAMP_RED;

    tl_lamp_decode #(.OWN_DIR(d[0])) u_dec (
      .phase    (phase_d),
      .dir      (dir_d),
      .flash_lit(cnt_d[0]),
      .lamp     (lamp_d[d])
    );

    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) begin
        lamp_q[d] <= START;
      end else if (step_en) begin
        lamp_q[d] <= lamp_d[d];
      end
    end
  end

  assign ew_red   = lamp_q[0].red;
  assign ew_amber = lamp_q[0].amber;
  assign ew_go    = lamp_q[0].go;
  assign ns_red   = lamp_q[1].red;
  assign ns_amber = lamp_q[1].amber;
  assign ns_go    = lamp_q[1].go;

endmodule

// File: rtl/tl_crossing_chk.sv
module tl_crossing_chk (
  input logic clk,
  input logic rst_n,
  input logic ew_red,
  input logic ew_amber,
  input logic ew_go,
  input logic ns_red,
  input logic ns_amber,
  input logic ns_go
);

  // R7: the two ambers never light together
  p_amber_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ew_amber && ns_amber));

  // R8: at most one lamp per road
  p_one_lamp_ew_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ew_red, ew_amber, ew_go}));

  p_one_lamp_ns_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ns_red, ns_amber, ns_go}));

  // R5: amber ending is replaced by red in the same cycle
  p_amber_to_red_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ew_amber) |-> ew_red);

  // R6: while one road may move, the other shows red
  p_cross_red_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ew_go || ew_amber) |-> ns_red);

  p_cross_red_ns_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ns_go || ns_amber) |-> ew_red);

endmodule

bind tl_crossing_ctrl tl_crossing_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ew_red  (ew_red),
  .ew_amber(ew_amber),
  .ew_go   (ew_go),
  .ns_red  (ns_red),
  .ns_amber(ns_amber),
  .ns_go   (ns_go)
);

// File: tb/sim_tl_crossing_ctrl.sv
`timescale 1ns/1ps
module sim_tl_crossing_ctrl;

  localparam int GO_N    = 7;
  localparam int FLASH_N = 4;
  localparam int AMBER_N = 3;
  localparam int TURN    = GO_N + FLASH_N + AMBER_N;
  localparam int ROUND   = 2 * TURN;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ew_red, ew_amber, ew_go, ns_red, ns_amber, ns_go;

  int n_checks = 0;
  int n_errors = 0;
  int pos = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  tl_crossing_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .ew_red(ew_red), .ew_amber(ew_amber), .ew_go(ew_go),
    .ns_red(ns_red), .ns_amber(ns_amber), .ns_go(ns_go)
  );

  // Lamps {red, amber, green} of one road at a position inside its own turn.
  function automatic logic [2:0] road_lamps(int p);
    if (p < GO_N)                       return 3'b001;
    if (p < GO_N + FLASH_N)             return ((p - GO_N) % 2 == 1) ? 3'b001 : 3'b000;
    if (p < TURN)                       return 3'b010;
    return 3'b100;
  endfunction

  function automatic logic [5:0] expect_at(int p);
    return {road_lamps(p), road_lamps((p + TURN) % ROUND)};
  endfunction

  function automatic string tag_of(int p);
    int q = p % TURN;
    if (p >= TURN)             return "R6";
    if (q < GO_N)              return "R3";
    if (q < GO_N + FLASH_N)    return "R4";
    return "R5";
  endfunction

  function automatic logic [5:0] outs();
    return {ew_red, ew_amber, ew_go, ns_red, ns_amber, ns_go};
  endfunction

  task automatic chk(string tag, logic [5:0] act, logic [5:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s pos=%0d actual=%b expected=%b", tag, pos, act, exp);
    end
  endtask

  task automatic report();
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  // Per-cycle check at the current position, plus the invariants.
  task automatic chk_cycle();
    logic [5:0] o;
    o = outs();
    chk(tag_of(pos), o, expect_at(pos));
    chk("R7", {5'b0, o[4] & o[1]}, 6'b0);
    chk("R8", {4'b0, ($countones(o[5:3]) > 1), ($countones(o[2:0]) > 1)}, 6'b0);
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      pos = (pos + 1) % ROUND;
      chk_cycle();
    end
  endtask

  // Release reset at a falling edge, verify the synchronizer hold, start at 0.
  task automatic release_and_hold();
    @(negedge clk);
    rst_n = 1'b1;
    pos = 0;
    for (int e = 0; e < 2; e++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R2", outs(), expect_at(0));
    end
  endtask

  initial begin
    // R1: outputs during reset
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", outs(), 6'b001_100);
    release_and_hold();
    // R3..R6: three full rounds, then into the amber phase
    step(3 * ROUND + GO_N + FLASH_N + 1);
    // R9: asynchronous reset in the middle of amber
    #0.5;
    rst_n = 1'b0;
    #0.5;
    chk("R9", outs(), 6'b001_100);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R9", outs(), 6'b001_100);
    release_and_hold();
    step(ROUND + 3);
    finished = 1'b1;
    report();
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog pos=%0d actual=timeout expected=done", pos);
      report();
    end
  end

endmodule